// File: doc/BRIEF.md
# Paged Address Translation Map

This block turns a 24-bit bus address into a physical address within 256 KB of board memory. It holds a table of 1024 page entries that the host writes. For each lookup it drops the top four address bits. It uses the next ten bits to pick an entry and joins that entry's frame number to the 10-bit page offset. Each entry also carries a byte-order flag and a memory-location flag. Both flags go out with the translated address, so the data path can swap bytes and route the access one page at a time.

The host has a table access port with byte enables, so entries can be updated 16 or 8 bits at a time. It also has its own combinational lookup port. The network controller reaches the same table through a valid/ready lookup channel. The channel is a combinational pass-through. The result is valid in the cycle the request is valid. The request is accepted only when the consumer asserts ready, and ready travels straight back upstream. The block holds no result while the consumer stalls. The controller's boot pointer sits at 0xFFFFF4, which falls in entry 1023, so software fills that entry before it releases the controller.

Top module: `pgmap_xlate`

## Requirements
- R1: Physical address bits 9:0 equal lookup address bits 9:0 on both lookup ports.
- R2: Lookup address bits 19:10 select the table entry. Bits 23:20 have no effect on any lookup output.
- R3: When the entry's frame number (bits 11:0) is below 256, the physical address is {frame[7:0], offset}. This gives an 18-bit result.
- R4: When the frame number is 256 or more, the error output is 1 and physical address bits 17:10 are 0.
- R5: The swap output equals entry bit 15 (1 = swap the two bytes of each 16-bit word, 0 = little-endian). The auxiliary-bus select output equals entry bit 13 (1 = backplane memory, 0 = on-board memory).
- R6: A table write is captured at a clock edge. Lookups and the table read port show the new value from that edge on, and not before it.
- R7: Write byte enable bit 0 writes entry bits 7:0 and bit 1 writes bits 15:8. A lane whose enable is 0 keeps its old value. An enable of 00 writes nothing.
- R8: After reset, every entry reads as 0x0000.
- R9: Controller channel: ctl_out_valid equals ctl_valid and ctl_ready equals ctl_out_ready. The result shows in the same cycle.
- R10: The host and controller ports translate through the same table, so equal addresses give equal results. Address 0xFFFFF4 translates through entry 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the table |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 10 | Entry index for table read and write |
| tbl_be | input | 2 | Byte enables for the write |
| tbl_wdata | input | 16 | Write data |
| tbl_rdata | output | 16 | Entry contents at tbl_idx |
| hst_addr | input | 24 | Host lookup address |
| hst_paddr | output | 18 | Host physical address |
| hst_swap | output | 1 | Host byte-order flag |
| hst_aux | output | 1 | Host backplane-memory select |
| hst_err | output | 1 | Host out-of-range frame |
| ctl_valid | input | 1 | Controller request valid |
| ctl_ready | output | 1 | Controller request accepted |
| ctl_addr | input | 24 | Controller lookup address |
| ctl_out_valid | output | 1 | Controller result valid |
| ctl_out_ready | input | 1 | Downstream ready for the result |
| ctl_paddr | output | 18 | Controller physical address |
| ctl_swap | output | 1 | Controller byte-order flag |
| ctl_aux | output | 1 | Controller backplane-memory select |
| ctl_err | output | 1 | Controller out-of-range frame |

## Verification
The assertions assume that tbl_we, tbl_be and the controller handshake inputs hold known values from reset onward. They also assume that a write index does not change in the middle of a clock edge. The bench drives every input on the falling edge and holds it through the next rising edge. It uses only the 01, 10, 11 and 00 enable patterns, and it keeps ctl_valid low except in the handshake tests.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;
  localparam int ADDR_W_D     = 24;
  localparam int OFS_W_D      = 10;
  localparam int IDX_W_D      = 10;
  localparam int ENT_W_D      = 16;
  localparam int FRAME_W_D    = 12;
  localparam int PHYS_PAGES_D = 256;
  localparam int SWAP_BIT_D   = 15;
  localparam int AUX_BIT_D    = 13;

  typedef struct packed {
    logic swap;
    logic aux;
    logic err;
  } xl_flags_t;
endpackage

// File: rtl/pgmap_table.sv
module pgmap_table #(
  parameter int IDX_W = pgmap_pkg::IDX_W_D,
  parameter int ENT_W = pgmap_pkg::ENT_W_D,
  parameter int NRD   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          widx,
  input  logic [ENT_W/8-1:0]        be,
  input  logic [ENT_W-1:0]          wdata,
  input  logic [NRD-1:0][IDX_W-1:0] ridx,
  output logic [NRD-1:0][ENT_W-1:0] rdata
);
  localparam int NENT = 1 << IDX_W;
  localparam int NB   = ENT_W / 8;

  logic [ENT_W-1:0] mem [NENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) mem[e] <= '0;
    end else if (we) begin
      for (int l = 0; l < NB; l++)
        if (be[l]) mem[widx][l*8 +: 8] <= wdata[l*8 +: 8];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[ridx[p]];
  end

  for (genvar l = 0; l < NB; l++) begin : g_lane_chk
    a_r7_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !be[l]) |=> (mem[$past(widx)][l*8 +: 8] == $past(mem[widx][l*8 +: 8])));
    a_r6_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
      (we && be[l]) |=> (mem[$past(widx)][l*8 +: 8] == $past(wdata[l*8 +: 8])));
  end
endmodule

// File: rtl/pgmap_lookup.sv
module pgmap_lookup #(
  parameter int OFS_W      = pgmap_pkg::OFS_W_D,
  parameter int ENT_W      = pgmap_pkg::ENT_W_D,
  parameter int FRAME_W    = pgmap_pkg::FRAME_W_D,
  parameter int PHYS_PAGES = pgmap_pkg::PHYS_PAGES_D,
  parameter int SWAP_BIT   = pgmap_pkg::SWAP_BIT_D,
  parameter int AUX_BIT    = pgmap_pkg::AUX_BIT_D,
  localparam int PPN_W     = $clog2(PHYS_PAGES),
  localparam int PADDR_W   = PPN_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ENT_W-1:0]      entry,
  input  logic [OFS_W-1:0]      offset,
  output logic [PADDR_W-1:0]    paddr,
  output pgmap_pkg::xl_flags_t  flags
);
  logic [FRAME_W-1:0] frame;
  logic               oor;

  assign frame      = entry[FRAME_W-1:0];
  assign oor        = (frame >= FRAME_W'(PHYS_PAGES));
  assign paddr      = {(oor ? {PPN_W{1'b0}} : frame[PPN_W-1:0]), offset};
  assign flags.swap = entry[SWAP_BIT];
  assign flags.aux  = entry[AUX_BIT];
  assign flags.err  = oor;

  a_r4_err_page0: assert property (@(posedge clk) disable iff (!rst_n)
    flags.err |-> (paddr[PADDR_W-1:OFS_W] == '0));
  a_r3_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !flags.err |-> (entry[FRAME_W-1:PPN_W] == '0));
endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate #(
  parameter int ADDR_W     = pgmap_pkg::ADDR_W_D,
  parameter int OFS_W      = pgmap_pkg::OFS_W_D,
  parameter int IDX_W      = pgmap_pkg::IDX_W_D,
  parameter int ENT_W      = pgmap_pkg::ENT_W_D,
  parameter int PHYS_PAGES = pgmap_pkg::PHYS_PAGES_D,
  localparam int PPN_W     = $clog2(PHYS_PAGES),
  localparam int PADDR_W   = PPN_W + OFS_W,
  localparam int BE_W      = ENT_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [BE_W-1:0]    tbl_be,
  input  logic [ENT_W-1:0]   tbl_wdata,
  output logic [ENT_W-1:0]   tbl_rdata,
  input  logic [ADDR_W-1:0]  hst_addr,
  output logic [PADDR_W-1:0] hst_paddr,
  output logic               hst_swap,
  output logic               hst_aux,
  output logic               hst_err,
  input  logic               ctl_valid,
  output logic               ctl_ready,
  input  logic [ADDR_W-1:0]  ctl_addr,
  output logic               ctl_out_valid,
  input  logic               ctl_out_ready,
  output logic [PADDR_W-1:0] ctl_paddr,
  output logic               ctl_swap,
  output logic               ctl_aux,
  output logic               ctl_err
);
  localparam int NLK = 2;

  logic [NLK-1:0][ADDR_W-1:0]  lk_addr;
  logic [NLK-1:0][PADDR_W-1:0] lk_paddr;
  pgmap_pkg::xl_flags_t        lk_flags [NLK];
  logic [NLK:0][IDX_W-1:0]     rd_idx;
  logic [NLK:0][ENT_W-1:0]     rd_ent;

  assign lk_addr[0] = hst_addr;
  assign lk_addr[1] = ctl_addr;
  assign rd_idx[0]  = tbl_idx;

  pgmap_table #(.IDX_W(IDX_W), .ENT_W(ENT_W), .NRD(NLK + 1)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .be(tbl_be),
    .wdata(tbl_wdata), .ridx(rd_idx), .rdata(rd_ent)
  );

  for (genvar k = 0; k < NLK; k++) begin : g_lk
    assign rd_idx[k+1] = lk_addr[k][OFS_W +: IDX_W];
    pgmap_lookup #(.OFS_W(OFS_W), .ENT_W(ENT_W), .PHYS_PAGES(PHYS_PAGES)) u_lk (
      .clk(clk), .rst_n(rst_n), .entry(rd_ent[k+1]),
      .offset(lk_addr[k][OFS_W-1:0]), .paddr(lk_paddr[k]), .flags(lk_flags[k])
    );
  end

  assign tbl_rdata     = rd_ent[0];
  assign hst_paddr     = lk_paddr[0];
  assign hst_swap      = lk_flags[0].swap;
  assign hst_aux       = lk_flags[0].aux;
  assign hst_err       = lk_flags[0].err;
  assign ctl_paddr     = lk_paddr[1];
  assign ctl_swap      = lk_flags[1].swap;
  assign ctl_aux       = lk_flags[1].aux;
  assign ctl_err       = lk_flags[1].err;
  assign ctl_out_valid = ctl_valid;
  assign ctl_ready     = ctl_out_ready;

  a_r10_shared_table: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_addr[OFS_W+IDX_W-1:0] == ctl_addr[OFS_W+IDX_W-1:0]) |->
      (hst_paddr == ctl_paddr && hst_swap == ctl_swap && hst_aux == ctl_aux && hst_err == ctl_err));
  a_r1_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_paddr[OFS_W-1:0] == hst_addr[OFS_W-1:0]) && (ctl_paddr[OFS_W-1:0] == ctl_addr[OFS_W-1:0]));
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_out_valid && !ctl_out_ready) |-> !ctl_ready);
  a_r6_table_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tbl_we) && $stable(tbl_idx)) |-> $stable(tbl_rdata));
endmodule

// File: tb/pgmap_xlate_bench.sv
module pgmap_xlate_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        tbl_we = 0;
  logic [9:0]  tbl_idx = '0;
  logic [1:0]  tbl_be = '0;
  logic [15:0] tbl_wdata = '0;
  logic [15:0] tbl_rdata;
  logic [23:0] hst_addr = '0;
  logic [17:0] hst_paddr;
  logic        hst_swap, hst_aux, hst_err;
  logic        ctl_valid = 0;
  logic        ctl_ready;
  logic [23:0] ctl_addr = '0;
  logic        ctl_out_valid;
  logic        ctl_out_ready = 0;
  logic [17:0] ctl_paddr;
  logic        ctl_swap, ctl_aux, ctl_err;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pgmap_xlate u_pgmap_xlate (.*);

  // {addr[23:0], paddr[17:0], swap, aux, err}
  localparam logic [44:0] VEC [9] = '{
    {24'h000000, 18'h00000, 3'b000},
    {24'h000523, 18'h01523, 3'b100},
    {24'hF00523, 18'h01523, 3'b100},
    {24'h0008AB, 18'h3FCAB, 3'b010},
    {24'h000C3F, 18'h0003F, 3'b001},
    {24'hFFFFF4, 18'h01FF4, 3'b110},
    {24'h0FFFFF, 18'h01FFF, 3'b110},
    {24'h080155, 18'h00155, 3'b001},
    {24'h001001, 18'h00001, 3'b000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [9:0] idx, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    tbl_we = 1; tbl_idx = idx; tbl_be = be; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: reset state
    tbl_idx = 10'd1;    #1 check("R8 entry1", tbl_rdata, 16'h0000);
    tbl_idx = 10'd1023; #1 check("R8 entry1023", tbl_rdata, 16'h0000);

    // R6: write is not visible before the edge, visible after
    @(negedge clk);
    tbl_we = 1; tbl_idx = 10'd1; tbl_be = 2'b11; tbl_wdata = 16'h8005;
    #1 check("R6 before edge", tbl_rdata, 16'h0000);
    @(negedge clk);
    tbl_we = 0;
    #1 check("R6 after edge", tbl_rdata, 16'h8005);

    wr(10'd2, 2'b11, 16'h20FF);
    wr(10'd3, 2'b11, 16'h0100);
    wr(10'd1023, 2'b11, 16'hA007);
    wr(10'd512, 2'b11, 16'h0FFF);

    // R1 R2 R3 R4 R5 R10: vector walk on both ports
    foreach (VEC[i]) begin
      @(negedge clk);
      hst_addr = VEC[i][44:21];
      ctl_addr = VEC[i][44:21];
      #1;
      check("R3 R1 R2 host paddr", hst_paddr, VEC[i][20:3]);
      check("R10 ctl paddr", ctl_paddr, VEC[i][20:3]);
      check("R5 host swap/aux", {hst_swap, hst_aux}, VEC[i][2:1]);
      check("R5 ctl swap/aux", {ctl_swap, ctl_aux}, VEC[i][2:1]);
      check("R4 err host/ctl", {hst_err, ctl_err}, {2{VEC[i][0]}});
    end

    // R7: byte-lane writes on entry 1 (currently 0x8005)
    wr(10'd1, 2'b01, 16'h3309);
    tbl_idx = 10'd1; #1 check("R7 low lane only", tbl_rdata, 16'h8009);
    wr(10'd1, 2'b10, 16'h2044);
    tbl_idx = 10'd1; #1 check("R7 high lane only", tbl_rdata, 16'h2009);
    wr(10'd1, 2'b00, 16'hFFFF);
    tbl_idx = 10'd1; #1 check("R7 no enables", tbl_rdata, 16'h2009);
    hst_addr = 24'h000400; #1;
    check("R7 lookup after lanes", {hst_paddr, hst_swap, hst_aux}, {18'h02400, 2'b01});

    // R9: handshake pass-through
    @(negedge clk);
    ctl_valid = 1; ctl_out_ready = 0; #1;
    check("R9 stall", {ctl_out_valid, ctl_ready}, 2'b10);
    ctl_out_ready = 1; #1;
    check("R9 accept", {ctl_out_valid, ctl_ready}, 2'b11);
    ctl_valid = 0; #1;
    check("R9 idle", {ctl_out_valid, ctl_ready}, 2'b01);

    // R8: reset clears the table again
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    tbl_idx = 10'd1023; #1 check("R8 re-reset", tbl_rdata, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule